// File: doc/BRIEF.md
# Operating Mode Control Register

This block holds the operating mode of an 8-bit microcontroller and a pair of configuration bits that depend on it. While reset is held low it keeps sampling two mode strap pins. The values present when reset is released stay in a special-mode flag and a mode-select flag. Together the two flags name one of four chip modes. After that, the CPU reads and writes the register through a simple strobe port. Each bit has its own write rule, and the rule depends on whether the chip currently runs in a special mode or a normal mode.

Two enables go to the rest of the chip. The first makes the boot loader ROM visible, and it is only honoured in special modes. The second drives internal read data onto the external bus, and it is only honoured in the modes that have an external bus. In normal modes the visibility bit accepts one write after reset and then locks. The special-mode flag can be cleared by software, but nothing except a new reset can set it again.

Top module: `opmode_ctrl`

## Requirements
- R1: While `rst_n` is low, each clock edge loads the special-mode flag with the inverse of `mode_pin_b` and the mode-select flag with `mode_pin_a`. The values from the last edge before release are kept.
- R2: `mode_out` is {special flag, select flag}, where 00 = single-chip, 01 = expanded, 10 = special bootstrap and 11 = special test.
- R3: A write updates the special flag from `wr_data[6]` and the select flag from `wr_data[5]` only if the special flag was 1 before that write. In normal modes (`mode_out[1]` = 0), writes leave `mode_out` unchanged.
- R4: Once the special flag is 0, no write can set it back to 1 until the next reset.
- R5: The stored boot ROM bit is written from `wr_data[7]` only in special modes. `boot_en` is the stored bit ANDed with the special flag.
- R6: In special modes every write loads the stored visibility bit from `wr_data[4]`. In normal modes only the first write after reset loads it, and later writes leave it unchanged until the next reset.
- R7: `vis_en` is the stored visibility bit, forced to 0 when `mode_out` is 00 or 10.
- R8: With `rd_en` high, `rd_data` shows the boot bit on bit 7, the special flag on bit 6, the select flag on bit 5, the visibility bit on bit 4, and 0 on bits 3..0. With `rd_en` low, `rd_data` is all zeros.
- R9: On reset the boot bit takes 1 when the captured mode is special bootstrap (10) and 0 otherwise. The visibility bit and its write-once lock take 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode pins are captured while it is low |
| mode_pin_b | input | 1 | Mode strap B; its inverse becomes the special-mode flag |
| mode_pin_a | input | 1 | Mode strap A; copied into the mode-select flag |
| wr_en | input | 1 | Register write strobe, one write per cycle it is high |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, zero when `rd_en` is low |
| mode_out | output | 2 | Current {special, select} mode flags |
| boot_en | output | 1 | Effective boot loader ROM enable |
| vis_en | output | 1 | Effective internal read visibility enable |

## Verification
The reset-capture check assumes that the strap pins hold steady over the last clock edge before `rst_n` rises. The bench sets the pins first and keeps them fixed for several cycles of reset and through the release. The stickiness and write-once checks assume that reset is the only path back to special mode and to an unlocked visibility bit, and the bench changes no pin after release. All strobes and data are driven on the falling edge, so every write is seen once, at a single rising edge, and never mid-cycle.

// File: rtl/opmode_pkg.sv
// Package: shared widths, bit positions and the mode encoding of the
// operating mode control register. Assumes an 8-bit CPU data path.
package opmode_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_BOOT  = 7;
    localparam int BIT_SPEC  = 6;
    localparam int BIT_SEL   = 5;
    localparam int BIT_VIS   = 4;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_BOOT     = 2'b10,
        MODE_TEST     = 2'b11
    } opmode_e;
endpackage

// File: rtl/opmode_mode_bits.sv
// Module: holds the special-mode flag and the mode-select flag.
// While reset is low the flags track the strap pins; afterwards they are
// writable only while the special flag is set, which also makes the special
// flag impossible to set again once cleared.
// Assumes: wr_spec/wr_sel are the data bits at their register positions.
module opmode_mode_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    input  logic wr_en,
    input  logic wr_spec,
    input  logic wr_sel,
    output logic spec_q,
    output logic sel_q
);
    // Purpose: capture the straps in reset, gated software update after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q <= ~pin_b;
            sel_q  <= pin_a;
        end else if (wr_en && spec_q) begin
            spec_q <= wr_spec;
            sel_q  <= wr_sel;
        end
    end
endmodule

// File: rtl/opmode_cfg_bits.sv
// Module: stores the boot ROM bit and the read visibility bit.
// The boot bit is writable only in special modes; its reset value marks the
// special bootstrap strap setting. The visibility bit is free in special
// modes and write-once in normal modes, tracked by a lock flag.
// Assumes: spec_q is the pre-write special flag from opmode_mode_bits.
module opmode_cfg_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    input  logic spec_q,
    input  logic wr_en,
    input  logic wr_boot,
    input  logic wr_vis,
    output logic boot_q,
    output logic vis_q,
    output logic vis_lock_q
);
    logic vis_wr_ok;

    // Purpose: decide whether this write may touch the visibility bit.
    always_comb begin
        vis_wr_ok = wr_en && (spec_q || !vis_lock_q);
    end

    // Purpose: boot bit with strap-derived reset value, special-only writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= ~pin_b & ~pin_a;
        end else if (wr_en && spec_q) begin
            boot_q <= wr_boot;
        end
    end

    // Purpose: visibility bit and its normal-mode write-once lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q      <= 1'b0;
            vis_lock_q <= 1'b0;
        end else begin
            if (vis_wr_ok) begin
                vis_q <= wr_vis;
            end
            if (wr_en && !spec_q) begin
                vis_lock_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/opmode_readback.sv
// Module: assembles the read view of the register from the stored bits.
// Unassigned positions read zero; the whole bus is zero without a read.
// Assumes: bit positions from opmode_pkg are distinct and below REG_W.
module opmode_readback
    import opmode_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         rd_en,
    input  logic         boot_q,
    input  logic         spec_q,
    input  logic         sel_q,
    input  logic         vis_q,
    output logic [W-1:0] rd_data
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == BIT_BOOT) begin : g_boot
            assign rd_data[i] = rd_en & boot_q;
        end else if (i == BIT_SPEC) begin : g_spec
            assign rd_data[i] = rd_en & spec_q;
        end else if (i == BIT_SEL) begin : g_sel
            assign rd_data[i] = rd_en & sel_q;
        end else if (i == BIT_VIS) begin : g_vis
            assign rd_data[i] = rd_en & vis_q;
        end else begin : g_zero
            assign rd_data[i] = 1'b0;
        end
    end
endmodule

// File: rtl/opmode_ctrl.sv
// Module: top of the operating mode control register. It ties together the
// mode flags, the configuration bits and the read view, and gates the two
// enables by the current mode.
// Assumes: one register, strobes sampled on the rising clock edge.
module opmode_ctrl
    import opmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pin_b,
    input  logic             mode_pin_a,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    output logic [1:0]       mode_out,
    output logic             boot_en,
    output logic             vis_en
);
    logic spec_q;
    logic sel_q;
    logic boot_q;
    logic vis_q;
    logic vis_lock_q;
    opmode_e mode_cur;

    opmode_mode_bits u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_a   (mode_pin_a),
        .pin_b   (mode_pin_b),
        .wr_en   (wr_en),
        .wr_spec (wr_data[BIT_SPEC]),
        .wr_sel  (wr_data[BIT_SEL]),
        .spec_q  (spec_q),
        .sel_q   (sel_q)
    );

    opmode_cfg_bits u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_a      (mode_pin_a),
        .pin_b      (mode_pin_b),
        .spec_q     (spec_q),
        .wr_en      (wr_en),
        .wr_boot    (wr_data[BIT_BOOT]),
        .wr_vis     (wr_data[BIT_VIS]),
        .boot_q     (boot_q),
        .vis_q      (vis_q),
        .vis_lock_q (vis_lock_q)
    );

    opmode_readback #(.W(REG_W)) u_rd (
        .rd_en   (rd_en),
        .boot_q  (boot_q),
        .spec_q  (spec_q),
        .sel_q   (sel_q),
        .vis_q   (vis_q),
        .rd_data (rd_data)
    );

    // Purpose: decode the mode and gate the enables by it.
    always_comb begin
        mode_cur = opmode_e'({spec_q, sel_q});
        mode_out = mode_cur;
        boot_en  = boot_q & spec_q;
        vis_en   = vis_q & ((mode_cur == MODE_EXPANDED) || (mode_cur == MODE_TEST));
    end
endmodule

// File: rtl/opmode_ctrl_chk.sv
// Module: assertion checker for opmode_ctrl, attached by bind below.
// Assumes the strap pins are steady across the edge before reset release.
module opmode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_pin_a,
    input logic       mode_pin_b,
    input logic       wr_en,
    input logic [1:0] mode_out,
    input logic       boot_en,
    input logic       vis_en,
    input logic       vis_q
);
    logic seen_nwr;

    // Purpose: remember a normal-mode write since the last reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_nwr <= 1'b0;
        else if (wr_en && !mode_out[1]) seen_nwr <= 1'b1;
    end

    // R1
    reset_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_out == {~$past(mode_pin_b), $past(mode_pin_a)}));
    // R4
    special_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$rose(mode_out[1]));
    // R3
    normal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_out[1])) |-> $stable(mode_out));
    // R5
    boot_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_en |-> mode_out[1]);
    // R7
    vis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vis_en |-> mode_out[0]);
    // R6
    vis_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_out[1] && seen_nwr) |=> $stable(vis_q));
endmodule

bind opmode_ctrl opmode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pin_a (mode_pin_a),
    .mode_pin_b (mode_pin_b),
    .wr_en      (wr_en),
    .mode_out   (mode_out),
    .boot_en    (boot_en),
    .vis_en     (vis_en),
    .vis_q      (vis_q)
);

// File: tb/opmode_ctrl_bench.sv
`timescale 1ns/1ps
module opmode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pin_b = 1'b0;
    logic       mode_pin_a = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b1;
    logic [7:0] rd_data;
    logic [1:0] mode_out;
    logic       boot_en;
    logic       vis_en;

    int n_run = 0;
    int n_fail = 0;
    logic ms, ma, mb, mv, mlk;

    always #2 clk = ~clk;

    opmode_ctrl u_opmode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_pin_b(mode_pin_b), .mode_pin_a(mode_pin_a),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .mode_out(mode_out), .boot_en(boot_en), .vis_en(vis_en)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Compare every output with the bench model.
    task automatic chk_all();
        chk("R8 rd_data", rd_data, {mb, ms, ma, mv, 4'b0000});
        chk("R2 mode_out", {6'b0, mode_out}, {6'b0, ms, ma});
        chk("R5 boot_en", {7'b0, boot_en}, {7'b0, mb & ms});
        chk("R7 vis_en", {7'b0, vis_en}, {7'b0, mv & ma});
    endtask

    task automatic do_reset(input logic pb, input logic pa);
        @(negedge clk);
        rst_n = 1'b0; mode_pin_b = pb; mode_pin_a = pa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ms = ~pb; ma = pa; mb = ~pb & ~pa; mv = 1'b0; mlk = 1'b0;
        chk("R1 capture", {6'b0, mode_out}, {6'b0, ~pb, pa});
        chk("R9 boot/vis reset", {rd_data[7], rd_data[4]}, {~pb & ~pa, 1'b0});
        chk_all();
    endtask

    task automatic do_write(input logic [7:0] d);
        logic old_s;
        old_s = ms;
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (old_s) begin
            mb = d[7]; ms = d[6]; ma = d[5]; mv = d[4];
        end else if (!mlk) begin
            mv = d[4]; mlk = 1'b1;
        end
        if (!old_s) chk("R4 special stays clear", {7'b0, mode_out[1]}, 8'h00);
        if (!old_s) chk("R3 normal ignores mode", {6'b0, mode_out}, {6'b0, ms, ma});
        chk("R6 vis bit", {7'b0, rd_data[4]}, {7'b0, mv});
        chk_all();
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 16; v++) begin
                logic [3:0] hv;
                hv = v[3:0];
                do_reset(p[1], p[0]);
                do_write({hv, 4'hA});
                do_write({~hv, 4'h5});
                do_write({hv, 4'hF});
                do_write({~hv, 4'h0});
                rd_en = 1'b0;
                #1 chk("R8 no read", rd_data, 8'h00);
                rd_en = 1'b1;
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule